// File: doc/BRIEF.md
# Hook-Driven Debug Controller

This block sits next to a host datapath and services debug hooks. When the host reaches an instrumented point it pulses a hook strobe carrying a hook code. In the same cycle the controller evaluates every small procedure installed for that hook. If none of them asks to stop, the host is released in that same cycle and pays no extra cycles. If at least one asks to stop, the controller switches from batch mode to interactive mode, reports the hook code, and stalls the host.

A director talks to the controller over a command stream with one command per cycle and one reply per command. It can read, write or increment a variable, install a procedure, force a stop, and resume. Variables are addressed by a numeric code. The low codes are host variables, which the host presents as inputs and receives back as per-variable write strobes. The next codes are debug registers held inside the controller. Procedures can only be installed while the host is stalled, so debug code never changes while the host runs.

Each procedure slot holds an enable bit, a two-bit operation, a variable code and a constant. Three operations stop on a condition: always, equal, and greater-or-equal. The fourth is a bounded counter: it stops once its variable has reached the constant, and otherwise increments the variable and lets the host continue.

Top module: `hook_dbg_ctrl`

## Requirements
- R1: After reset the controller is in batch mode (host_stall low), every procedure slot is empty and every debug register reads 0.
- R2: In batch mode a hook strobe whose procedures do not stop raises hook_go in the same cycle, and host_stall stays low.
- R3: A procedure word is {enable[PW-1], op[PW-2:PW-3], var code[DATA_W+VAR_W-1:DATA_W], constant[DATA_W-1:0]}. Ops 0, 1 and 2 stop when, respectively, always, when var equals the constant, and when var is greater than or equal to it. On a stop, hook_go stays low in that cycle; in the next cycle brk_vld pulses with brk_hook equal to the hook code, and host_stall is high.
- R4: Op 3 (counter) stops when its variable is greater than or equal to the constant; otherwise it increments the variable by one, visible one cycle later. A variable is incremented at most once per hook event, even when several counters of that hook name it.
- R5: All enabled procedures of a hook are evaluated in parallel. The hook stops if any of them stops, and the increments from the counters that did not stop are still applied.
- R6: host_stall stays high until a continue command (op 4), after which it is low one cycle later. A stop command (op 5) sets host_stall one cycle later. Both reply OK.
- R7: A hook strobe while host_stall is high is ignored: hook_go stays low, there is no brk_vld, and no counter moves.
- R8: Install (op 3) writes cmd_proc into slot cmd_slot of hook cmd_hook only in interactive mode. In batch mode it replies REJECTED_MODE (1), checked before any code, and leaves the table unchanged.
- R9: Read (op 0), write (op 1) and increment (op 2) act on codes 0..HOST_VARS-1 (host variables) and on the following DBG_REGS codes (debug registers), in either mode. They reply OK (0) with the read value, the written value, or the incremented value (wrapping modulo 2^DATA_W). A host-variable change is signalled through host_we_o and host_wdata_o one cycle after the command.
- R10: An unknown variable code, an install with an unknown hook code or an unknown variable code in the procedure, and command ops 6 and 7 reply BAD_ID (2) with data 0 and change nothing.
- R11: A hook strobe with a code at or above NUM_HOOKS behaves as continue: hook_go is high in the same cycle.
- R12: When a write or increment command and a counter increment target the same variable in the same cycle, the command's value wins.
- R13: Every command produces exactly one reply, one cycle later. Reads return the value the variable had in the command's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hook_vld | input | 1 | Single-cycle hook strobe from the host |
| hook_id | input | HOOK_W | Code of the hook reached |
| hook_go | output | 1 | Host may proceed past the hook (same cycle) |
| host_stall | output | 1 | Controller is in interactive mode; host holds |
| host_vars_i | input | HOST_VARS*DATA_W | Current host variable values |
| host_we_o | output | HOST_VARS | Per-variable write strobe to the host |
| host_wdata_o | output | HOST_VARS*DATA_W | New host variable values |
| brk_vld | output | 1 | A hook caused a stop |
| brk_hook | output | HOOK_W | Code of the hook that caused the stop |
| cmd_vld | input | 1 | Director command valid |
| cmd_op | input | 3 | Command operation |
| cmd_var | input | VAR_W | Variable code |
| cmd_hook | input | HOOK_W | Hook code for install |
| cmd_slot | input | SLOT_W | Procedure slot for install |
| cmd_data | input | DATA_W | Write data |
| cmd_proc | input | PW | Procedure word for install |
| rsp_vld | output | 1 | Reply valid |
| rsp_status | output | 2 | 0 OK, 1 REJECTED_MODE, 2 BAD_ID |
| rsp_data | output | DATA_W | Reply data |

## Verification
The bench builds the default configuration: four hooks with two slots each, two host variables, two debug registers and 8-bit data. With three-bit variable and hook codes, this makes the full code space small enough to sweep. Every variable code from 0 to 7 and every hook code from 0 to 7 is exercised, so the four invalid codes in each space are covered. Each condition operation is tried on every hook with the constant one below, equal to and one above the variable. The 8-bit width brings the increment wrap from 255 to 0 within reach, and the two slots allow a stopping procedure to share a hook with a counter.

// File: rtl/hook_dbg_ctrl.sv
module hook_dbg_ctrl #(
  parameter int NUM_HOOKS = 4,
  parameter int PROCS     = 2,
  parameter int HOST_VARS = 2,
  parameter int DBG_REGS  = 2,
  parameter int DATA_W    = 8,
  localparam int NV     = HOST_VARS + DBG_REGS,
  localparam int VAR_W  = $clog2(NV) + 1,
  localparam int HOOK_W = $clog2(NUM_HOOKS) + 1,
  localparam int SLOT_W = (PROCS > 1) ? $clog2(PROCS) : 1,
  localparam int PW     = 3 + VAR_W + DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hook_vld,
  input  logic [HOOK_W-1:0]             hook_id,
  output logic                          hook_go,
  output logic                          host_stall,
  input  logic [HOST_VARS*DATA_W-1:0]   host_vars_i,
  output logic [HOST_VARS-1:0]          host_we_o,
  output logic [HOST_VARS*DATA_W-1:0]   host_wdata_o,
  output logic                          brk_vld,
  output logic [HOOK_W-1:0]             brk_hook,
  input  logic                          cmd_vld,
  input  logic [2:0]                    cmd_op,
  input  logic [VAR_W-1:0]              cmd_var,
  input  logic [HOOK_W-1:0]             cmd_hook,
  input  logic [SLOT_W-1:0]             cmd_slot,
  input  logic [DATA_W-1:0]             cmd_data,
  input  logic [PW-1:0]                 cmd_proc,
  output logic                          rsp_vld,
  output logic [1:0]                    rsp_status,
  output logic [DATA_W-1:0]             rsp_data
);
  localparam int NP = NUM_HOOKS * PROCS;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_INC = 3'd2,
                         OP_INST = 3'd3, OP_CONT = 3'd4, OP_BRK = 3'd5;
  localparam logic [1:0] ST_OK = 2'd0, ST_REJ = 2'd1, ST_BAD = 2'd2;

  logic              interactive_q;
  logic [PW-1:0]     proc_q [NP];
  logic [DATA_W-1:0] dbg_q  [DBG_REGS];
  logic [DATA_W-1:0] var_val [NV];
  logic [DATA_W-1:0] var_nxt [NV];
  logic [NV-1:0]     var_we;

  genvar gi;
  for (gi = 0; gi < NV; gi++) begin : g_vars
    if (gi < HOST_VARS) begin : g_host
      assign var_val[gi] = host_vars_i[gi*DATA_W +: DATA_W];
    end else begin : g_dbg
      assign var_val[gi] = dbg_q[gi-HOST_VARS];
    end
  end

  assign host_stall = interactive_q;

  logic          brk_any, eval_en, hook_brk;
  logic [NV-1:0] inc_mask;

  always_comb begin
    brk_any  = 1'b0;
    inc_mask = '0;
    for (int p = 0; p < PROCS; p++) begin
      logic [PW-1:0]     pw;
      logic [VAR_W-1:0]  pv;
      logic [DATA_W-1:0] pk, v;
      logic              fire;
      pw = '0;
      for (int h = 0; h < NUM_HOOKS; h++)
        if (hook_id == HOOK_W'(h)) pw = proc_q[h*PROCS+p];
      pv = pw[DATA_W +: VAR_W];
      pk = pw[DATA_W-1:0];
      v  = '0;
      for (int i = 0; i < NV; i++)
        if (pv == VAR_W'(i)) v = var_val[i];
      case (pw[PW-2 -: 2])
        2'd0:    fire = 1'b1;
        2'd1:    fire = (v == pk);
        default: fire = (v >= pk);
      endcase
      if (pw[PW-1]) begin
        if (fire) brk_any = 1'b1;
        else if (pw[PW-2 -: 2] == 2'd3)
          for (int i = 0; i < NV; i++)
            if (pv == VAR_W'(i)) inc_mask[i] = 1'b1;
      end
    end
  end

  assign eval_en  = hook_vld && !interactive_q && (hook_id < HOOK_W'(NUM_HOOKS));
  assign hook_brk = eval_en && brk_any;
  assign hook_go  = hook_vld && !interactive_q && !hook_brk;

  logic [1:0]        st;
  logic [DATA_W-1:0] dat, cur;
  logic              cv_ok, ch_ok, pv_ok, var_cmd;

  always_comb begin
    cur = '0;
    for (int i = 0; i < NV; i++)
      if (cmd_var == VAR_W'(i)) cur = var_val[i];
    cv_ok = cmd_var < VAR_W'(NV);
    ch_ok = cmd_hook < HOOK_W'(NUM_HOOKS);
    pv_ok = cmd_proc[DATA_W +: VAR_W] < VAR_W'(NV);
    st  = ST_OK;
    dat = '0;
    case (cmd_op)
      OP_RD:   begin st = cv_ok ? ST_OK : ST_BAD; dat = cur; end
      OP_WR:   begin st = cv_ok ? ST_OK : ST_BAD; dat = cmd_data; end
      OP_INC:  begin st = cv_ok ? ST_OK : ST_BAD; dat = cur + DATA_W'(1); end
      OP_INST: st = !interactive_q ? ST_REJ : ((ch_ok && pv_ok) ? ST_OK : ST_BAD);
      OP_CONT, OP_BRK: st = ST_OK;
      default: st = ST_BAD;
    endcase
    if (st != ST_OK) dat = '0;
  end

  assign var_cmd = cmd_vld && (st == ST_OK) && (cmd_op == OP_WR || cmd_op == OP_INC);

  always_comb begin
    for (int i = 0; i < NV; i++) begin
      if (var_cmd && cmd_var == VAR_W'(i)) begin
        var_nxt[i] = dat;
        var_we[i]  = 1'b1;
      end else if (eval_en && inc_mask[i]) begin
        var_nxt[i] = var_val[i] + DATA_W'(1);
        var_we[i]  = 1'b1;
      end else begin
        var_nxt[i] = var_val[i];
        var_we[i]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interactive_q <= 1'b0;
      for (int j = 0; j < NP; j++) proc_q[j] <= '0;
      for (int j = 0; j < DBG_REGS; j++) dbg_q[j] <= '0;
      host_we_o    <= '0;
      host_wdata_o <= '0;
      brk_vld      <= 1'b0;
      brk_hook     <= '0;
      rsp_vld      <= 1'b0;
      rsp_status   <= ST_OK;
      rsp_data     <= '0;
    end else begin
      rsp_vld    <= cmd_vld;
      rsp_status <= cmd_vld ? st : ST_OK;
      rsp_data   <= cmd_vld ? dat : '0;
      brk_vld    <= hook_brk;
      brk_hook   <= hook_brk ? hook_id : '0;
      if (hook_brk)                         interactive_q <= 1'b1;
      else if (cmd_vld && cmd_op == OP_BRK)  interactive_q <= 1'b1;
      else if (cmd_vld && cmd_op == OP_CONT) interactive_q <= 1'b0;
      if (cmd_vld && cmd_op == OP_INST && st == ST_OK)
        for (int h = 0; h < NUM_HOOKS; h++)
          for (int p = 0; p < PROCS; p++)
            if (cmd_hook == HOOK_W'(h) && cmd_slot == SLOT_W'(p))
              proc_q[h*PROCS+p] <= cmd_proc;
      for (int j = 0; j < DBG_REGS; j++)
        if (var_we[HOST_VARS+j]) dbg_q[j] <= var_nxt[HOST_VARS+j];
      for (int i = 0; i < HOST_VARS; i++) begin
        host_we_o[i] <= var_we[i];
        host_wdata_o[i*DATA_W +: DATA_W] <= var_nxt[i];
      end
    end
  end
endmodule

module hook_dbg_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hook_vld,
  input logic       hook_go,
  input logic       host_stall,
  input logic       brk_vld,
  input logic       cmd_vld,
  input logic [2:0] cmd_op,
  input logic       rsp_vld,
  input logic [1:0] rsp_status
);
  assert_go_or_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hook_vld && !host_stall && !hook_go) |=> brk_vld);
  assert_stop_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_vld |-> host_stall);
  assert_stall_blocks_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_stall |-> !hook_go);
  assert_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd4 && !hook_vld) |=> !host_stall);
  assert_ignore_hook_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hook_vld && host_stall) |=> !brk_vld);
  assert_install_batch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd3 && !host_stall) |=> (rsp_vld && rsp_status == 2'd1));
  assert_reply_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> rsp_vld);
  assert_no_spurious_reply_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !rsp_vld);
endmodule

bind hook_dbg_ctrl hook_dbg_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hook_vld(hook_vld), .hook_go(hook_go),
  .host_stall(host_stall), .brk_vld(brk_vld), .cmd_vld(cmd_vld),
  .cmd_op(cmd_op), .rsp_vld(rsp_vld), .rsp_status(rsp_status)
);

// File: tb/hook_dbg_ctrl_test.sv
module hook_dbg_ctrl_test;
  localparam int DW = 8, VW = 3, HW = 3, PWD = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic hook_vld = 0, hook_go, host_stall, brk_vld, cmd_vld = 0, rsp_vld;
  logic [HW-1:0] hook_id = '0, brk_hook, cmd_hook = '0;
  logic [2*DW-1:0] host_vars_i, host_wdata_o;
  logic [1:0] host_we_o, rsp_status;
  logic [2:0] cmd_op = '0;
  logic [VW-1:0] cmd_var = '0;
  logic cmd_slot = 1'b0;
  logic [DW-1:0] cmd_data = '0, rsp_data;
  logic [PWD-1:0] cmd_proc = '0;
  logic [DW-1:0] hv [2];

  assign host_vars_i = {hv[1], hv[0]};
  always @(negedge clk)
    for (int i = 0; i < 2; i++) if (host_we_o[i]) hv[i] <= host_wdata_o[i*DW +: DW];

  hook_dbg_ctrl uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic r_vld, g_go, g_bv, g_st;
  logic [1:0] r_st;
  logic [DW-1:0] r_dat;
  logic [1:0] r_we;
  logic [HW-1:0] g_bh;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [VW-1:0] v, input logic [HW-1:0] h,
                        input logic s, input logic [DW-1:0] d, input logic [PWD-1:0] p);
    @(negedge clk);
    cmd_vld = 1; cmd_op = op; cmd_var = v; cmd_hook = h; cmd_slot = s; cmd_data = d; cmd_proc = p;
    @(negedge clk);
    cmd_vld = 0;
    r_vld = rsp_vld; r_st = rsp_status; r_dat = rsp_data; r_we = host_we_o;
  endtask

  task automatic do_hook(input logic [HW-1:0] id);
    @(negedge clk);
    hook_vld = 1; hook_id = id;
    #1 g_go = hook_go;
    @(negedge clk);
    hook_vld = 0;
    g_bv = brk_vld; g_bh = brk_hook; g_st = host_stall;
  endtask

  function automatic logic [PWD-1:0] mkp(input logic en, input logic [1:0] op,
                                          input logic [VW-1:0] v, input logic [DW-1:0] k);
    return {en, op, v, k};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    hv[0] = 8'h11; hv[1] = 8'h22;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 stall after reset", host_stall, 0);
    for (int c = 2; c < 4; c++) begin
      do_cmd(3'd0, VW'(c), 0, 0, 0, 0);
      chk("R1 debug reg zero", r_dat, 0);
      chk("R13 reply valid", r_vld, 1);
    end
    for (int h = 0; h < 4; h++) begin
      do_hook(HW'(h));
      chk("R2 empty hook go", g_go, 1);
      chk("R2 no stall", g_st, 0);
    end
    do_cmd(3'd3, 0, 0, 0, 0, mkp(1, 0, 2, 0));
    chk("R8 batch install rejected", r_st, 1);
    do_hook(0);
    chk("R8 table unchanged", g_go, 1);
    @(negedge clk);
    chk("R13 no reply when idle", rsp_vld, 0);
    do_cmd(3'd5, 0, 0, 0, 0, 0);
    chk("R6 stop command", host_stall, 1);

    for (int h = 0; h < 4; h++)
      for (int op = 0; op < 3; op++)
        for (int d = 0; d < 3; d++) begin
          logic [DW-1:0] k;
          logic exp;
          k = DW'(4 + d);
          exp = (op == 0) ? 1'b1 : (op == 1) ? (k == 8'd5) : (8'd5 >= k);
          do_cmd(3'd1, 2, 0, 0, 8'd5, 0);
          do_cmd(3'd3, 0, HW'(h), 0, 0, mkp(1, 2'(op), 2, k));
          chk("R8 install interactive", r_st, 0);
          do_cmd(3'd4, 0, 0, 0, 0, 0);
          chk("R6 continue", host_stall, 0);
          do_hook(HW'(h));
          chk("R3 go", g_go, !exp);
          chk("R3 brk_vld", g_bv, exp);
          chk("R3 stall", g_st, exp);
          if (exp) chk("R3 brk_hook", g_bh, h);
          else do_cmd(3'd5, 0, 0, 0, 0, 0);
          do_cmd(3'd3, 0, HW'(h), 0, 0, 0);
        end

    do_cmd(3'd1, 3, 0, 0, 0, 0);
    do_cmd(3'd3, 0, 1, 1, 0, mkp(1, 3, 3, 3));
    do_cmd(3'd4, 0, 0, 0, 0, 0);
    for (int n = 0; n < 4; n++) begin
      do_hook(1);
      chk("R4 counter go", g_go, n != 3);
      chk("R4 counter stop", g_bv, n == 3);
      do_cmd(3'd0, 3, 0, 0, 0, 0);
      chk("R4 counter value", r_dat, (n == 3) ? 3 : n + 1);
    end

    do_cmd(3'd1, 2, 0, 0, 8'd7, 0);
    do_cmd(3'd3, 0, 2, 0, 0, mkp(1, 3, 2, 100));
    do_hook(2);
    chk("R7 no go while stalled", g_go, 0);
    chk("R7 no stop report", g_bv, 0);
    do_cmd(3'd0, 2, 0, 0, 0, 0);
    chk("R7 counter frozen", r_dat, 7);

    do_cmd(3'd3, 0, 2, 1, 0, mkp(1, 0, 0, 0));
    do_cmd(3'd4, 0, 0, 0, 0, 0);
    do_hook(2);
    chk("R5 stop wins", g_go, 0);
    chk("R5 stop hook", g_bh, 2);
    do_cmd(3'd0, 2, 0, 0, 0, 0);
    chk("R5 counter still applied", r_dat, 8);

    do_cmd(3'd3, 0, 2, 1, 0, mkp(1, 3, 2, 100));
    do_cmd(3'd4, 0, 0, 0, 0, 0);
    do_hook(2);
    chk("R4 two counters go", g_go, 1);
    do_cmd(3'd0, 2, 0, 0, 0, 0);
    chk("R4 single increment", r_dat, 9);

    @(negedge clk);
    hook_vld = 1; hook_id = 2;
    cmd_vld = 1; cmd_op = 3'd1; cmd_var = 2; cmd_data = 8'd50;
    @(negedge clk);
    hook_vld = 0; cmd_vld = 0;
    do_cmd(3'd0, 2, 0, 0, 0, 0);
    chk("R12 write beats counter", r_dat, 50);
    @(negedge clk);
    hook_vld = 1; hook_id = 2;
    cmd_vld = 1; cmd_op = 3'd2; cmd_var = 2;
    @(negedge clk);
    hook_vld = 0; cmd_vld = 0;
    do_cmd(3'd0, 2, 0, 0, 0, 0);
    chk("R12 increment beats counter", r_dat, 51);

    for (int h = 4; h < 8; h++) begin
      do_hook(HW'(h));
      chk("R11 unknown hook go", g_go, 1);
      chk("R11 unknown hook no stall", g_st, 0);
    end

    for (int c = 0; c < 8; c++) begin
      logic ok;
      ok = (c < 4);
      do_cmd(3'd1, VW'(c), 0, 0, DW'(8'h30 + c), 0);
      chk(ok ? "R9 write status" : "R10 bad var write", r_st, ok ? 0 : 2);
      chk("R9 host write strobe", r_we, (c < 2) ? (1 << c) : 0);
      @(negedge clk);
      if (c < 2) chk("R9 host variable updated", hv[c], 8'h30 + c);
      do_cmd(3'd0, VW'(c), 0, 0, 0, 0);
      chk(ok ? "R13 read back" : "R10 bad var read", r_dat, ok ? 8'h30 + c : 0);
      do_cmd(3'd2, VW'(c), 0, 0, 0, 0);
      chk(ok ? "R9 inc reply" : "R10 bad var inc", {r_st, r_dat}, ok ? 8'h31 + c : 32'h200);
    end
    do_cmd(3'd1, 3, 0, 0, 8'd255, 0);
    do_cmd(3'd2, 3, 0, 0, 0, 0);
    chk("R9 inc wraps", r_dat, 0);
    do_cmd(3'd0, 3, 0, 0, 0, 0);
    chk("R9 wrapped value", r_dat, 0);

    do_cmd(3'd3, 0, 5, 0, 0, mkp(1, 0, 0, 0));
    chk("R8 mode checked first", r_st, 1);
    do_cmd(3'd5, 0, 0, 0, 0, 0);
    do_cmd(3'd3, 0, 4, 0, 0, mkp(1, 0, 0, 0));
    chk("R10 bad hook install", r_st, 2);
    do_cmd(3'd3, 0, 0, 0, 0, mkp(1, 0, 5, 0));
    chk("R10 bad proc var", r_st, 2);
    do_cmd(3'd6, 0, 0, 0, 0, 0);
    chk("R10 op 6", r_st, 2);
    do_cmd(3'd7, 0, 0, 0, 0, 0);
    chk("R10 op 7", r_st, 2);
    do_cmd(3'd4, 0, 0, 0, 0, 0);
    do_hook(0);
    chk("R10 rejected install left hook empty", g_go, 1);

    summary();
  end
endmodule